// File: doc/BRIEF.md
# Timing Output Source Policy Selector

This block decides, for each of seven timing outputs, which stored select code is handed to the downstream clock and orbit multiplexers. The seven outputs are three individual bunch clocks (first beam, second beam, reference), one main bunch clock, two orbits and one main orbit. Every output owns three select codes, one for manual operation, one for beam present and one for beam absent, plus one bit in a working-mode word that picks manual or automatic operation.

In automatic operation the choice between the beam and no-beam codes comes from a 32-entry policy bitmap. The bitmap is indexed by the machine mode number recovered from a timing broadcast. The same lookup drives a beam indicator output. All effective codes and the indicator are registered, so software and broadcast changes reach the multiplexers one clock after they are sampled.

Top module: `timing_src_policy`

## Requirements
- R1: When an output's working-mode bit is 0 (manual), its effective code equals its manual code, whatever the machine mode and policy bitmap hold.
- R2: Working-mode bit positions are: bit 0 first-beam bunch clock, bit 1 second-beam bunch clock, bit 2 reference bunch clock, bit 3 main bunch clock, bit 4 first orbit, bit 5 second orbit, bit 6 main orbit; 1 selects automatic operation for that output only.
- R3: In automatic operation, when policy bit number `machine_mode` is 1, the effective code equals the output's beam code.
- R4: In automatic operation, when policy bit number `machine_mode` is 0, the effective code equals the output's no-beam code (mode 0 = no beam, 1 = filling, 2 = ramping, 3 = physics are ordinary indices).
- R5: A machine mode of 32 or more is treated as no-beam: automatic outputs take their no-beam code and the beam indicator is 0.
- R6: The beam indicator `beam_q` equals policy bit number `machine_mode` (0 for modes of 32 or more), independent of the working-mode word.
- R7: Main orbit codes are 0 first orbit, 1 second orbit, 2 internal orbit; a chosen code of 3 is presented as 2.
- R8: All outputs are registered: an input change takes effect at the first rising clock edge after it and not before.
- R9: While `rst_n` is low all effective codes and `beam_q` are 0.
- R10: Individual bunch-clock and orbit codes are 1 bit (bunch clock: 0 internal, 1 input; orbit: 0 input, 1 internal); the main bunch-clock code is 2 bits (0 internal, 1 reference, 2 second beam, 3 first beam) and passes through unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| work_auto | input | 7 | Per-output automatic enable, order per R2 |
| beam_policy | input | 32 | Beam policy bit per machine mode |
| machine_mode | input | 8 | Current machine mode number |
| bc_man_code | input | 3 | Manual codes, bunch clocks (bit i = clock i) |
| bc_beam_code | input | 3 | Beam codes, bunch clocks |
| bc_nobeam_code | input | 3 | No-beam codes, bunch clocks |
| bcm_man_code | input | 2 | Manual code, main bunch clock |
| bcm_beam_code | input | 2 | Beam code, main bunch clock |
| bcm_nobeam_code | input | 2 | No-beam code, main bunch clock |
| orb_man_code | input | 2 | Manual codes, orbits (bit i = orbit i) |
| orb_beam_code | input | 2 | Beam codes, orbits |
| orb_nobeam_code | input | 2 | No-beam codes, orbits |
| orbm_man_code | input | 2 | Manual code, main orbit |
| orbm_beam_code | input | 2 | Beam code, main orbit |
| orbm_nobeam_code | input | 2 | No-beam code, main orbit |
| bc_sel_q | output | 3 | Effective bunch-clock codes |
| bcm_sel_q | output | 2 | Effective main bunch-clock code |
| orb_sel_q | output | 2 | Effective orbit codes |
| orbm_sel_q | output | 2 | Effective main orbit code |
| beam_q | output | 1 | Beam indicator |

## Verification
The per-output properties assume the stored code they compare against is within the legal range for that output; for the main orbit they only fire when the chosen code is 0 to 2, and the out-of-range value 3 is covered by a separate property on the output. They also assume inputs are steady around each rising edge, which the stimulus guarantees by changing every input just after the falling edge. The machine mode is swept past 32 so the out-of-range lookup is reached, and the working-mode word is walked one bit at a time with manual, beam and no-beam codes set to distinct values, so any swapped bit or swapped set shows as a mismatch.

// File: rtl/tsel_pkg.sv
package tsel_pkg;

   // which of the three stored codes drives an output
   typedef enum logic [1:0] {
      SET_MANUAL = 2'd0,
      SET_BEAM   = 2'd1,
      SET_NOBEAM = 2'd2
   } set_e;

   function automatic set_e pick_set(input logic auto_en, input logic beam_on);
      if (!auto_en)     return SET_MANUAL;
      else if (beam_on) return SET_BEAM;
      else              return SET_NOBEAM;
   endfunction

endpackage

// File: rtl/tsel_mode_lookup.sv
module tsel_mode_lookup #(
   parameter int MODE_W = 8,
   parameter int POL_W  = 32
) (
   input  logic [MODE_W-1:0] mode_i,
   input  logic [POL_W-1:0]  policy_i,
   output logic              beam_o
);
   localparam int IDX_W = $clog2(POL_W);
   localparam logic [MODE_W:0] POL_LIM = (MODE_W+1)'(POL_W);

   if (POL_W < 2)      begin : g_bad_pol  $error("POL_W must be at least 2"); end
   if (MODE_W < IDX_W) begin : g_bad_mode $error("MODE_W too narrow to index the policy"); end

   logic in_range;

   always_comb begin
      in_range = ({1'b0, mode_i} < POL_LIM);
      beam_o   = in_range && policy_i[mode_i[IDX_W-1:0]];
   end

endmodule

// File: rtl/tsel_out_stage.sv
module tsel_out_stage
   import tsel_pkg::*;
#(
   parameter int W        = 1,
   parameter int CODE_MAX = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         auto_i,
   input  logic         beam_i,
   input  logic [W-1:0] man_i,
   input  logic [W-1:0] beam_code_i,
   input  logic [W-1:0] nob_code_i,
   output logic [W-1:0] sel_q
);
   localparam logic [W-1:0] CODE_LIM = W'(CODE_MAX);
   localparam int           FULL_MAX = (1 << W) - 1;

   if (W < 1 || W > 8)                  begin : g_bad_w   $error("W out of range"); end
   if (CODE_MAX < 1 || CODE_MAX > FULL_MAX) begin : g_bad_max $error("CODE_MAX out of range"); end

   set_e         act;
   logic [W-1:0] pick;
   logic [W-1:0] pick_fit;

   always_comb begin
      act = pick_set(auto_i, beam_i);
      unique case (act)
         SET_BEAM:   pick = beam_code_i;
         SET_NOBEAM: pick = nob_code_i;
         default:    pick = man_i;
      endcase
   end

   // clamp variant only when the code space has illegal values
   if (CODE_MAX < FULL_MAX) begin : g_clamp
      assign pick_fit = (pick > CODE_LIM) ? CODE_LIM : pick;
   end else begin : g_pass
      assign pick_fit = pick;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else        sel_q <= pick_fit;
   end

   // R1
   manual_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!auto_i && man_i <= CODE_LIM) |=> (sel_q == $past(man_i)));

   // R3
   beam_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_i && beam_i && beam_code_i <= CODE_LIM) |=> (sel_q == $past(beam_code_i)));

   // R4
   nobeam_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_i && !beam_i && nob_code_i <= CODE_LIM) |=> (sel_q == $past(nob_code_i)));

   // R7
   code_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sel_q <= CODE_LIM);

endmodule

// File: rtl/timing_src_policy.sv
module timing_src_policy #(
   parameter int N_BC   = 3,
   parameter int N_ORB  = 2,
   parameter int MODE_W = 8,
   parameter int POL_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [N_BC+N_ORB+1:0]         work_auto,
   input  logic [POL_W-1:0]              beam_policy,
   input  logic [MODE_W-1:0]             machine_mode,
   input  logic [N_BC-1:0]               bc_man_code,
   input  logic [N_BC-1:0]               bc_beam_code,
   input  logic [N_BC-1:0]               bc_nobeam_code,
   input  logic [1:0]                    bcm_man_code,
   input  logic [1:0]                    bcm_beam_code,
   input  logic [1:0]                    bcm_nobeam_code,
   input  logic [N_ORB-1:0]              orb_man_code,
   input  logic [N_ORB-1:0]              orb_beam_code,
   input  logic [N_ORB-1:0]              orb_nobeam_code,
   input  logic [1:0]                    orbm_man_code,
   input  logic [1:0]                    orbm_beam_code,
   input  logic [1:0]                    orbm_nobeam_code,
   output logic [N_BC-1:0]               bc_sel_q,
   output logic [1:0]                    bcm_sel_q,
   output logic [N_ORB-1:0]              orb_sel_q,
   output logic [1:0]                    orbm_sel_q,
   output logic                          beam_q
);
   // working-mode bit positions (R2)
   localparam int BCM_BIT  = N_BC;
   localparam int ORB0_BIT = N_BC + 1;
   localparam int ORBM_BIT = N_BC + N_ORB + 1;
   localparam int BCM_MAX  = 3;   // internal, reference, second, first
   localparam int ORBM_MAX = 2;   // first orbit, second orbit, internal
   localparam logic [MODE_W:0] POL_LIM = (MODE_W+1)'(POL_W);

   if (N_BC < 1 || N_ORB < 1) begin : g_bad_cnt   $error("need at least one clock and one orbit"); end
   if (MODE_W > 16)           begin : g_bad_modew $error("MODE_W too wide"); end

   logic beam_c;

   tsel_mode_lookup #(.MODE_W(MODE_W), .POL_W(POL_W)) u_lookup (
      .mode_i   (machine_mode),
      .policy_i (beam_policy),
      .beam_o   (beam_c)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) beam_q <= 1'b0;
      else        beam_q <= beam_c;
   end

   for (genvar i = 0; i < N_BC; i++) begin : g_bc
      tsel_out_stage #(.W(1), .CODE_MAX(1)) u_stage (
         .clk         (clk),
         .rst_n       (rst_n),
         .auto_i      (work_auto[i]),
         .beam_i      (beam_c),
         .man_i       (bc_man_code[i]),
         .beam_code_i (bc_beam_code[i]),
         .nob_code_i  (bc_nobeam_code[i]),
         .sel_q       (bc_sel_q[i])
      );
   end

   tsel_out_stage #(.W(2), .CODE_MAX(BCM_MAX)) u_bcm (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_i      (work_auto[BCM_BIT]),
      .beam_i      (beam_c),
      .man_i       (bcm_man_code),
      .beam_code_i (bcm_beam_code),
      .nob_code_i  (bcm_nobeam_code),
      .sel_q       (bcm_sel_q)
   );

   for (genvar j = 0; j < N_ORB; j++) begin : g_orb
      tsel_out_stage #(.W(1), .CODE_MAX(1)) u_stage (
         .clk         (clk),
         .rst_n       (rst_n),
         .auto_i      (work_auto[ORB0_BIT+j]),
         .beam_i      (beam_c),
         .man_i       (orb_man_code[j]),
         .beam_code_i (orb_beam_code[j]),
         .nob_code_i  (orb_nobeam_code[j]),
         .sel_q       (orb_sel_q[j])
      );
   end

   tsel_out_stage #(.W(2), .CODE_MAX(ORBM_MAX)) u_orbm (
      .clk         (clk),
      .rst_n       (rst_n),
      .auto_i      (work_auto[ORBM_BIT]),
      .beam_i      (beam_c),
      .man_i       (orbm_man_code),
      .beam_code_i (orbm_beam_code),
      .nob_code_i  (orbm_nobeam_code),
      .sel_q       (orbm_sel_q)
   );

   // R5
   mode_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, machine_mode} >= POL_LIM) |=> !beam_q);

   // R7
   orbm_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (orbm_sel_q != 2'd3));

   // R9
   reset_state_chk: assert property (@(posedge clk)
      !rst_n |-> (bc_sel_q == '0 && bcm_sel_q == '0 && orb_sel_q == '0
                  && orbm_sel_q == '0 && !beam_q));

endmodule

// File: tb/timing_src_policy_test.sv
`timescale 1ns/1ps
module timing_src_policy_test;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2.5 clk = ~clk;

   logic [6:0]  work;
   logic [31:0] pol;
   logic [7:0]  mode;
   logic [2:0]  bc_m, bc_b, bc_n;
   logic [1:0]  bcm_m, bcm_b, bcm_n;
   logic [1:0]  orb_m, orb_b, orb_n;
   logic [1:0]  om_m, om_b, om_n;

   logic [2:0] bc_q;
   logic [1:0] bcm_q, orb_q, om_q;
   logic       bq;

   timing_src_policy uut (
      .clk(clk), .rst_n(rst_n), .work_auto(work), .beam_policy(pol), .machine_mode(mode),
      .bc_man_code(bc_m), .bc_beam_code(bc_b), .bc_nobeam_code(bc_n),
      .bcm_man_code(bcm_m), .bcm_beam_code(bcm_b), .bcm_nobeam_code(bcm_n),
      .orb_man_code(orb_m), .orb_beam_code(orb_b), .orb_nobeam_code(orb_n),
      .orbm_man_code(om_m), .orbm_beam_code(om_b), .orbm_nobeam_code(om_n),
      .bc_sel_q(bc_q), .bcm_sel_q(bcm_q), .orb_sel_q(orb_q), .orbm_sel_q(om_q), .beam_q(bq)
   );

   int    n_chk = 0;
   int    n_fail = 0;
   string req = "R9";
   bit    running = 1'b0;

   // reference model state
   logic [2:0] e_bc;
   logic [1:0] e_bcm, e_orb, e_om;
   logic       e_beam;

   function automatic logic beam_of(int m, logic [31:0] p);
      return (m < 32) ? p[m] : 1'b0;
   endfunction

   function automatic int choose(logic a, logic b, int m, int bm, int nb);
      if (!a) return m;
      return b ? bm : nb;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         e_bc <= '0; e_bcm <= '0; e_orb <= '0; e_om <= '0; e_beam <= 1'b0;
      end else begin
         logic b;
         int   v;
         b = beam_of(int'(mode), pol);
         e_beam <= b;
         for (int i = 0; i < 3; i++)
            e_bc[i] <= 1'(choose(work[i], b, bc_m[i], bc_b[i], bc_n[i]));
         e_bcm <= 2'(choose(work[3], b, bcm_m, bcm_b, bcm_n));
         for (int i = 0; i < 2; i++)
            e_orb[i] <= 1'(choose(work[4+i], b, orb_m[i], orb_b[i], orb_n[i]));
         v = choose(work[6], b, om_m, om_b, om_n);
         e_om <= (v == 3) ? 2'd2 : 2'(v);
      end
   end

   task automatic chk(string tag, string what, int act, int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   task automatic cmp_all(string tag);
      chk(tag, "bc_sel_q",   bc_q,  e_bc);
      chk(tag, "bcm_sel_q",  bcm_q, e_bcm);
      chk(tag, "orb_sel_q",  orb_q, e_orb);
      chk(tag, "orbm_sel_q", om_q,  e_om);
      chk({"R6/", tag}, "beam_q", bq, e_beam);
   endtask

   always @(negedge clk) if (running) cmp_all(req);

   task automatic tick();
      @(negedge clk); #1;
   endtask

   // inputs just changed; outputs must not move before the edge
   task automatic hold_chk();
      #1;
      cmp_all("R8");
   endtask

   task automatic rnd_codes();
      bc_m = 3'($urandom); bc_b = 3'($urandom); bc_n = 3'($urandom);
      bcm_m = 2'($urandom); bcm_b = 2'($urandom); bcm_n = 2'($urandom);
      orb_m = 2'($urandom); orb_b = 2'($urandom); orb_n = 2'($urandom);
      om_m = 2'($urandom % 3); om_b = 2'($urandom % 3); om_n = 2'($urandom % 3);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      work = 7'h7F; pol = 32'hFFFF_FFFF; mode = 8'd3;
      bc_m = 3'b111; bc_b = 3'b111; bc_n = 3'b111;
      bcm_m = 2'd3; bcm_b = 2'd3; bcm_n = 2'd3;
      orb_m = 2'b11; orb_b = 2'b11; orb_n = 2'b11;
      om_m = 2'd2; om_b = 2'd2; om_n = 2'd2;
      running = 1'b1;
      // R9: reset holds everything at zero despite nonzero inputs
      repeat (4) tick();
      rst_n = 1'b1;

      // R1: manual everywhere, policy and mode irrelevant
      req = "R1";
      work = 7'h00;
      for (int k = 0; k < 20; k++) begin
         tick(); rnd_codes(); pol = $urandom; mode = 8'($urandom % 40); hold_chk();
      end

      // R2: one automatic bit at a time, three distinct code sets
      req = "R2";
      for (int b = 0; b < 7; b++) begin
         tick();
         work = 7'(1 << b);
         pol = 32'hFFFF_FFFF; mode = 8'd3;
         bc_m = 3'b000; bc_b = 3'b111; bc_n = 3'b000;
         bcm_m = 2'd0; bcm_b = 2'd3; bcm_n = 2'd1;
         orb_m = 2'b00; orb_b = 2'b11; orb_n = 2'b00;
         om_m = 2'd0; om_b = 2'd1; om_n = 2'd2;
         hold_chk();
         repeat (2) tick();
      end

      // R3 / R4 / R5: automatic, sweep mode across and past the bitmap
      work = 7'h7F;
      for (int s = 0; s < 2; s++) begin
         for (int m = 0; m < 40; m++) begin
            tick();
            pol = (s == 0) ? 32'h0000_000E : 32'hFFFF_FFF1;
            mode = 8'(m);
            bc_m = 3'($urandom); bc_b = 3'b111; bc_n = 3'b000;
            bcm_m = 2'($urandom); bcm_b = 2'd3; bcm_n = 2'd1;
            orb_m = 2'($urandom); orb_b = 2'b11; orb_n = 2'b00;
            om_m = 2'd0; om_b = 2'd1; om_n = 2'd2;
            hold_chk();
            if (m >= 32) req = "R5";
            else if (pol[m]) req = "R3";
            else req = "R4";
         end
      end
      tick(); mode = 8'd255; pol = 32'hFFFF_FFFF; req = "R5"; hold_chk();
      repeat (2) tick();

      // R7: main orbit code 3 from each set
      req = "R7";
      for (int k = 0; k < 12; k++) begin
         tick();
         rnd_codes();
         om_m = 2'd3; om_b = 2'd3; om_n = 2'd3;
         work = 7'($urandom); pol = $urandom; mode = 8'($urandom % 34);
         hold_chk();
      end

      // R10: random mix of every field
      req = "R10";
      for (int k = 0; k < 200; k++) begin
         tick();
         rnd_codes();
         if ((k % 5) == 0) om_b = 2'd3;
         work = 7'($urandom); pol = $urandom; mode = 8'($urandom % 48);
         hold_chk();
      end

      // R9: reset again mid-run
      req = "R9";
      tick(); rst_n = 1'b0;
      repeat (3) tick();
      running = 1'b0;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule